// File: doc/BRIEF.md
# Timer Channel Capture/Match Unit

This block is a single channel of a multi-channel timing peripheral. It keeps a 16-bit match value and a 16-bit capture value and watches two free-running time bases. A match fires when the chosen time base has reached or passed the stored match value. The test treats the 16-bit counter as circular, so a match value just ahead of a wrapping counter is still reached. A capture copies the chosen time base when a programmed edge arrives on the pin. The pin is first passed through a synchronizer.

An external controlling engine drives the channel. It chooses the pin direction, the time base for each half and the capture edge. It also chooses the pin action on a match, writes the match value and clears the event flags. The highest-numbered channel of a group is built with an output-disable input that forces its pin output low. Other channels set a parameter to leave this logic out.

Top module: `tmr_chan_cm`

## Requirements
- R1: While rst_ni is low, match_reg_o, cap_reg_o, match_flag_o, cap_flag_o and pin_o are 0. After reset the channel is unarmed, so no match fires until the match register is first written.
- R2: A match_wr_i strobe loads match_val_i into the match register, and match_reg_o shows it after that clock edge. The write arms the channel. No match can fire on the edge of the write itself.
- R3: When the channel is armed at a clock edge and ((timebase - match_reg) mod 2^16) < 2^15, match_flag_o is 1 after that edge. Equality counts as a match, and the test wraps around 0xFFFF.
- R4: match_tb_sel_i selects the match time base: 0 picks tb_a_i and 1 picks tb_b_i.
- R5: A match fires once per arming. After firing, no further match fires until match_wr_i is strobed again, even if the time base stays at or past the match value.
- R6: On a match, match_act_i sets the pin level: 00 holds it, 01 drives it to 1, 10 drives it to 0 and 11 toggles it. pin_oe_o follows dir_out_i (1 means output).
- R7: edge_mode_i selects the capture edge: 00 none, 01 rising, 10 falling, 11 either. If pin_i changes before clock edge k, the capture happens at edge k+2. cap_reg_o and cap_flag_o update after that edge and not earlier.
- R8: cap_tb_sel_i selects the capture time base: 0 picks tb_a_i and 1 picks tb_b_i.
- R9: While dir_out_i is 1, pin edges capture nothing. cap_reg_o and cap_flag_o stay unchanged.
- R10: match_flag_o and cap_flag_o stay set until clr_match_i or clr_cap_i is strobed. If a new event and a clear happen on the same edge, the flag ends up set.
- R11: With the output-disable variant built, out_dis_i high forces pin_o to 0 in the same cycle. The internal pin level is kept and reappears on pin_o once out_dis_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_a_i | input | 16 | Time base A |
| tb_b_i | input | 16 | Time base B |
| pin_i | input | 1 | Pin input level, asynchronous |
| dir_out_i | input | 1 | Pin direction: 1 output, 0 input |
| match_tb_sel_i | input | 1 | Match time base select |
| cap_tb_sel_i | input | 1 | Capture time base select |
| edge_mode_i | input | 2 | Capture edge mode |
| match_act_i | input | 2 | Pin action on match |
| match_wr_i | input | 1 | Match register write strobe |
| match_val_i | input | 16 | Match write data |
| clr_match_i | input | 1 | Match flag clear strobe |
| clr_cap_i | input | 1 | Capture flag clear strobe |
| out_dis_i | input | 1 | Forced output disable |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| match_reg_o | output | 16 | Match register |
| cap_reg_o | output | 16 | Capture register |
| match_flag_o | output | 1 | Sticky match event flag |
| cap_flag_o | output | 1 | Sticky capture event flag |

## Verification
The bench tries the comparison at equality, one count short, across the 0xFFFF wrap and at exactly half the range. A plain equality or unsigned test would miss the wrapped and passed cases, and an off-by-one would fire a count early. It holds the time base past the match after a match has fired, so a design that re-arms on its own would set the flag a second time. Each time-base select is tested with the other base set to give the opposite result, so a swapped multiplexer shows up as a wrong flag or a wrong captured value. It also samples the capture at each synchronizer stage, so a latency that is one cycle short or long is caught. Capturing in output mode, letting a clear beat a same-cycle event and losing the held pin level under output disable are each checked as well.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_HIGH   = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;
endpackage

// File: rtl/tcm_edge_sync.sv
module tcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                d_i,
  input  tcm_pkg::edge_mode_e mode_i,
  output logic                hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              s_lvl, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign s_lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_lvl;
  end

  assign rise = s_lvl & ~prev_q;
  assign fall = ~s_lvl & prev_q;

  always_comb begin
    unique case (mode_i)
      tcm_pkg::EDGE_RISE: hit_o = rise;
      tcm_pkg::EDGE_FALL: hit_o = fall;
      tcm_pkg::EDGE_BOTH: hit_o = rise | fall;
      default:            hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcm_match_unit.sv
module tcm_match_unit #(
  parameter int TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [TB_W-1:0] val_i,
  input  logic            clr_i,
  output logic [TB_W-1:0] match_q_o,
  output logic            flag_o,
  output logic            fire_o
);
  logic [TB_W-1:0] match_q, tb_sel, diff;
  logic            armed_q, flag_q, ge;

  assign tb_sel = sel_i ? tb_b_i : tb_a_i;
  // circular compare: reached when the distance past match is under half range
  assign diff   = tb_sel - match_q;
  assign ge     = ~diff[TB_W-1];
  assign fire_o = armed_q & ge & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_i) begin
      match_q <= val_i;
      armed_q <= 1'b1;
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (fire_o) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign match_q_o = match_q;
  assign flag_o    = flag_q;

  // R3
  fire_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ge && !wr_i) |=> flag_q);
  // R5
  flag_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(armed_q));
  // R10
  clear_wins_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fire_o) |=> !flag_q);
endmodule

// File: rtl/tcm_capture_unit.sv
module tcm_capture_unit #(
  parameter int TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            sel_i,
  input  logic            hit_i,
  input  logic            en_i,
  input  logic            clr_i,
  output logic [TB_W-1:0] cap_q_o,
  output logic            flag_o
);
  logic [TB_W-1:0] cap_q;
  logic            flag_q, take;

  assign take = hit_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (take) cap_q <= sel_i ? tb_b_i : tb_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (take)   flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign cap_q_o = cap_q;
  assign flag_o  = flag_q;

  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && en_i) |=> $stable(cap_q));
  // R7
  cap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && en_i) |=> flag_q);
endmodule

// File: rtl/tcm_pin_ctl.sv
module tcm_pin_ctl #(
  parameter bit HAS_ODIS = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  tcm_pkg::match_act_e act_i,
  input  logic                dir_out_i,
  input  logic                out_dis_i,
  output logic                pin_o,
  output logic                pin_oe_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (fire_i) begin
      unique case (act_i)
        tcm_pkg::ACT_HIGH:   lvl_d = 1'b1;
        tcm_pkg::ACT_LOW:    lvl_d = 1'b0;
        tcm_pkg::ACT_TOGGLE: lvl_d = ~lvl_q;
        default:             lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  if (HAS_ODIS) begin : g_odis
    assign pin_o = lvl_q & ~out_dis_i;
    // R11
    odis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_dis_i |-> !pin_o);
  end else begin : g_no_odis
    logic unused_dis;
    assign unused_dis = out_dis_i;
    assign pin_o      = lvl_q;
  end

  assign pin_oe_o = dir_out_i;
endmodule

// File: rtl/tmr_chan_cm.sv
module tmr_chan_cm #(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_ODIS    = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            pin_i,
  input  logic            dir_out_i,
  input  logic            match_tb_sel_i,
  input  logic            cap_tb_sel_i,
  input  logic [1:0]      edge_mode_i,
  input  logic [1:0]      match_act_i,
  input  logic            match_wr_i,
  input  logic [TB_W-1:0] match_val_i,
  input  logic            clr_match_i,
  input  logic            clr_cap_i,
  input  logic            out_dis_i,
  output logic            pin_o,
  output logic            pin_oe_o,
  output logic [TB_W-1:0] match_reg_o,
  output logic [TB_W-1:0] cap_reg_o,
  output logic            match_flag_o,
  output logic            cap_flag_o
);
  logic fire, hit;

  tcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .mode_i (tcm_pkg::edge_mode_e'(edge_mode_i)),
    .hit_o  (hit)
  );

  tcm_match_unit #(.TB_W(TB_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tb_a_i    (tb_a_i),
    .tb_b_i    (tb_b_i),
    .sel_i     (match_tb_sel_i),
    .wr_i      (match_wr_i),
    .val_i     (match_val_i),
    .clr_i     (clr_match_i),
    .match_q_o (match_reg_o),
    .flag_o    (match_flag_o),
    .fire_o    (fire)
  );

  tcm_capture_unit #(.TB_W(TB_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tb_a_i  (tb_a_i),
    .tb_b_i  (tb_b_i),
    .sel_i   (cap_tb_sel_i),
    .hit_i   (hit),
    .en_i    (~dir_out_i),
    .clr_i   (clr_cap_i),
    .cap_q_o (cap_reg_o),
    .flag_o  (cap_flag_o)
  );

  tcm_pin_ctl #(.HAS_ODIS(HAS_ODIS)) u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .act_i     (tcm_pkg::match_act_e'(match_act_i)),
    .dir_out_i (dir_out_i),
    .out_dis_i (out_dis_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );
endmodule

// File: tb/tmr_chan_cm_tb_top.sv
module tmr_chan_cm_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tb_a_i = '0, tb_b_i = '0, match_val_i = '0;
  logic        pin_i = 1'b0, dir_out_i = 1'b1, match_tb_sel_i = 1'b0, cap_tb_sel_i = 1'b0;
  logic [1:0]  edge_mode_i = 2'b00, match_act_i = 2'b00;
  logic        match_wr_i = 1'b0, clr_match_i = 1'b0, clr_cap_i = 1'b0, out_dis_i = 1'b0;
  logic        pin_o, pin_oe_o, match_flag_o, cap_flag_o;
  logic [15:0] match_reg_o, cap_reg_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic        pin_model = 1'b0;
  logic [15:0] cap_model = '0;

  always #2 clk_i = ~clk_i;

  tmr_chan_cm dut_i (.*);

  function automatic bit ge_ref(logic [15:0] t, logic [15:0] m);
    logic [15:0] d;
    d = t - m;
    return d < 16'h8000;
  endfunction

  function automatic logic act_ref(logic [1:0] a, logic p);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~p;
      default: return p;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // R2 R3 R4 R5 R6 R10
  task automatic do_match(logic [15:0] m, logic [15:0] t, logic sel, logic [1:0] act);
    bit exp;
    logic [15:0] other;
    exp   = ge_ref(t, m);
    other = exp ? (m + 16'h8000) : m;
    dir_out_i = 1'b1; match_tb_sel_i = sel; match_act_i = act;
    tb_a_i = sel ? other : t;
    tb_b_i = sel ? t : other;
    match_wr_i = 1'b1; match_val_i = m;
    tick();
    match_wr_i = 1'b0;
    check("R2 match_reg", match_reg_o, m);
    check("R2 no fire on write", match_flag_o, 0);
    tick();
    check("R3/R4 match flag", match_flag_o, exp);
    if (exp) pin_model = act_ref(act, pin_model);
    check("R6 pin level", pin_o, pin_model);
    check("R6 pin oe", pin_oe_o, 1);
    clr_match_i = 1'b1;
    tick();
    clr_match_i = 1'b0;
    check("R10 cleared", match_flag_o, 0);
    tick();
    check("R5 no refire", match_flag_o, 0);
  endtask

  // R7 R8 R9
  task automatic do_cap(logic [1:0] mode, logic sel, logic [15:0] tv, logic dir);
    bit  rising, hit;
    rising = ~pin_i;
    hit = !dir && ((mode == 2'b11) || (mode == 2'b01 && rising) || (mode == 2'b10 && !rising));
    dir_out_i = dir; edge_mode_i = mode; cap_tb_sel_i = sel;
    tb_a_i = tv; tb_b_i = ~tv;
    pin_i = ~pin_i;
    tick();
    check("R7 latency stage1 flag", cap_flag_o, 0);
    tick();
    check("R7 latency stage2 reg", cap_reg_o, cap_model);
    tick();
    if (hit) cap_model = sel ? ~tv : tv;
    check("R7/R8/R9 cap_reg", cap_reg_o, cap_model);
    check("R7/R9 cap flag", cap_flag_o, hit);
    clr_cap_i = 1'b1;
    tick();
    clr_cap_i = 1'b0;
    check("R10 cap cleared", cap_flag_o, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 match_reg", match_reg_o, 0);
    check("R1 cap_reg", cap_reg_o, 0);
    check("R1 flags", {match_flag_o, cap_flag_o}, 0);
    check("R1 pin_o", pin_o, 0);
    rst_ni = 1'b1;
    tick(); tick();
    check("R1 unarmed after reset", match_flag_o, 0);

    // R3 corners
    do_match(16'd100, 16'd99, 1'b0, 2'b11);
    do_match(16'd100, 16'd100, 1'b0, 2'b11);
    do_match(16'd100, 16'd101, 1'b1, 2'b11);
    do_match(16'hFFF0, 16'h0010, 1'b0, 2'b01);
    do_match(16'h0010, 16'hFFF0, 1'b1, 2'b10);
    do_match(16'h0000, 16'h7FFF, 1'b1, 2'b10);
    do_match(16'h0000, 16'h8000, 1'b0, 2'b01);
    do_match(16'h1234, 16'h2000, 1'b0, 2'b00);

    for (int i = 0; i < 40; i++)
      do_match(16'($urandom), 16'($urandom), 1'($urandom), 2'($urandom));

    // R10 set beats clear
    match_tb_sel_i = 1'b0; tb_a_i = 16'd3;
    match_wr_i = 1'b1; match_val_i = 16'd5; match_act_i = 2'b01;
    tick();
    match_wr_i = 1'b0; tb_a_i = 16'd10; clr_match_i = 1'b1;
    tick();
    clr_match_i = 1'b0;
    pin_model = 1'b1;
    check("R10 set wins", match_flag_o, 1);
    // R11
    check("R11 level before", pin_o, 1);
    out_dis_i = 1'b1;
    #1;
    check("R11 forced low", pin_o, 0);
    tick();
    check("R11 still low", pin_o, 0);
    out_dis_i = 1'b0;
    #1;
    check("R11 level restored", pin_o, 1);
    clr_match_i = 1'b1; tick(); clr_match_i = 1'b0;

    // captures
    do_cap(2'b01, 1'b0, 16'hA5A5, 1'b0);
    do_cap(2'b01, 1'b0, 16'h1111, 1'b0);
    do_cap(2'b10, 1'b1, 16'h2222, 1'b0);
    do_cap(2'b00, 1'b0, 16'h3333, 1'b0);
    do_cap(2'b11, 1'b1, 16'h4444, 1'b0);
    do_cap(2'b11, 1'b0, 16'h5555, 1'b1);
    for (int i = 0; i < 30; i++)
      do_cap(2'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule